// File: doc/BRIEF.md
# Character-Row Raster Timing Core

This block produces the counter chain of a character-based display. A column counter steps once per character clock up to a programmable line length. Each completed line advances a raster counter inside the current character row. When the raster counter passes the programmed maximum, the row counter advances. After the final row, an optional run of vertical adjustment lines extends the frame before everything returns to the origin.

The end-of-frame decision is taken early in each line and then latched. Whether the current line is the last one is judged only while the column counter is 0 or 1. Whether adjustment lines follow is judged at column 2. A register write that lands later in the line therefore cannot change how that line ends. This lets software retune the frame geometry on the fly with predictable results. A line length of zero is not treated as a short line: it freezes the whole vertical chain until a nonzero value is written again.

A host writes the registers with two strobes. An address strobe selects a register and a data strobe writes it. The frame start address is copied into an output latch only when the counters sit at the frame origin. A one-cycle pulse marks each new frame.

Top module: `raster_chain_top`

## Requirements
- R1: While reset is held, and on release, the column, raster, row and adjustment counters are 0, `in_adjust`, `last_line` and `frame_start` are low, and `frame_base` is 0.
- R2: With a nonzero line length L, the column counter counts 0, 1, ..., L and then returns to 0.
- R3: The raster and row counters change only at the end of a line. The raster counter advances until it equals the maximum raster M, then returns to 0 while the row advances. With adjustment count 0 and line length L ≥ 2, a frame lasts (L+1)·(T+1)·(M+1) clocks, where T is the row total.
- R4: `last_line` reflects (raster = M and row = T) evaluated only while the column is 0 or 1. A write to M or T later in that line does not change whether the line ends the frame. A write made on the preceding line does change it.
- R5: Adjustment is armed at column 2 of the last line when the adjustment count is nonzero. Raising the count from 0 after column 2 adds no adjustment to that frame. Lowering it to 0 after arming still yields the adjustment line already started.
- R6: When armed, the frame is followed by adjustment lines with `in_adjust` high, raster and row 0, and `adj_cnt` 0, 1, .... An adjustment line ends the frame when `adj_cnt`+1 ≥ the current count. With count J, a frame lasts (L+1)·((T+1)·(M+1)+J) clocks.
- R7: A line length of 0 holds the column at 0 and holds raster, row, adjustment counter and `in_adjust` at their values. No `frame_start` occurs. Restoring a nonzero length resumes the line from column 0.
- R8: `frame_base` is loaded with the start address only in the clock after a cycle in which the counters are at the origin (column, raster and row all 0, not adjusting). Writes made mid-frame are not visible before then.
- R9: `frame_start` is high for exactly one clock, in the cycle when the counters first show the origin after a line end.
- R10: Register indices are 0 line length, 1 maximum raster, 2 row total, 3 adjustment count, 4 start address high (low 6 bits), 5 start address low. `host_addr_stb` loads the index from `host_data[2:0]`, and `host_data_stb` writes `host_data` into the selected register. When both strobes are high, only the index is loaded. Indices 6 and 7 write nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr_stb | input | 1 | Load register index from host_data[2:0] |
| host_data_stb | input | 1 | Write host_data into the selected register |
| host_data | input | 8 | Host index or data byte |
| col_cnt | output | 8 | Column counter |
| raster_cnt | output | 5 | Raster within character row |
| row_cnt | output | 7 | Character row counter |
| adj_cnt | output | 5 | Adjustment line counter |
| in_adjust | output | 1 | Adjustment lines in progress |
| last_line | output | 1 | Latched last-line verdict for the current line |
| frame_start | output | 1 | One-clock pulse at the frame origin |
| frame_base | output | 14 | Start address latched at the origin |

## Verification
Frame lengths are measured between origin pulses for several geometries: with no adjustment, with three adjustment lines, and after a row-total change. The measurements separate correct row wrap and adjustment insertion from off-by-one line counts. Row total and adjustment count are rewritten at column 5 of the last line, and on the preceding line. Together these show that the verdict is latched in its window and not re-evaluated continuously. A zero line length is applied both inside a row and inside the adjustment run, to show that every vertical counter holds. Writes with simultaneous strobes and to unused indices confirm that the decode leaves the geometry unchanged.

// File: rtl/raster_chain_pkg.sv
package raster_chain_pkg;
  typedef enum logic [2:0] {
    SEL_LINE_LEN  = 3'd0,
    SEL_MAX_RAS   = 3'd1,
    SEL_ROW_TOTAL = 3'd2,
    SEL_ADJ_CNT   = 3'd3,
    SEL_BASE_HI   = 3'd4,
    SEL_BASE_LO   = 3'd5,
    SEL_SPARE6    = 3'd6,
    SEL_SPARE7    = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/raster_host_regs.sv
module raster_host_regs
  import raster_chain_pkg::*;
#(
  parameter int DW  = 8,
  parameter int HW  = 8,
  parameter int RW  = 5,
  parameter int VW  = 7,
  parameter int JW  = 5,
  parameter int SAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           addr_stb,
  input  logic           data_stb,
  input  logic [DW-1:0]  data,
  output logic [HW-1:0]  line_len,
  output logic [RW-1:0]  max_ras,
  output logic [VW-1:0]  row_total,
  output logic [JW-1:0]  adj_total,
  output logic [SAW-1:0] start_addr
);
  localparam int HIW = SAW - DW;

  reg_sel_e          sel_q;
  logic [HIW-1:0]    base_hi_q;
  logic [DW-1:0]     base_lo_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sel_q     <= SEL_LINE_LEN;
      line_len  <= '0;
      max_ras   <= '0;
      row_total <= '0;
      adj_total <= '0;
      base_hi_q <= '0;
      base_lo_q <= '0;
    end else if (addr_stb) begin
      sel_q <= reg_sel_e'(data[2:0]);
    end else if (data_stb) begin
      case (sel_q)
        SEL_LINE_LEN:  line_len  <= data[HW-1:0];
        SEL_MAX_RAS:   max_ras   <= data[RW-1:0];
        SEL_ROW_TOTAL: row_total <= data[VW-1:0];
        SEL_ADJ_CNT:   adj_total <= data[JW-1:0];
        SEL_BASE_HI:   base_hi_q <= data[HIW-1:0];
        SEL_BASE_LO:   base_lo_q <= data;
        default: ;
      endcase
    end
  end

  assign start_addr = {base_hi_q, base_lo_q};

  // R10: an address strobe never alters a data register in the same cycle
  a_r10_addr_wins: assert property (@(posedge clk) disable iff (!rst_n)
    addr_stb |=> $stable(line_len) && $stable(row_total) && $stable(adj_total));
endmodule

// File: rtl/raster_hcount.sv
module raster_hcount #(
  parameter int HW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [HW-1:0] line_len,
  output logic [HW-1:0] col,
  output logic          frozen,
  output logic          line_end,
  output logic          win_last,
  output logic          win_adj
);
  localparam logic [HW-1:0] ONE = HW'(1);
  localparam logic [HW-1:0] TWO = HW'(2);

  assign frozen   = (line_len == '0);
  assign line_end = !frozen && (col == line_len);
  assign win_last = !frozen && (col < TWO);
  assign win_adj  = !frozen && (col == TWO);

  always_ff @(posedge clk) begin
    if (!rst_n)           col <= '0;
    else if (frozen)      col <= '0;
    else if (line_end)    col <= '0;
    else                  col <= col + ONE;
  end

  // R2: a completed line restarts at column 0
  a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> (col == '0));
  // R7: zero line length parks the column at 0
  a_r7_col_parked: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> (col == '0));
endmodule

// File: rtl/raster_vchain.sv
module raster_vchain #(
  parameter int RW = 5,
  parameter int VW = 7,
  parameter int JW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [RW-1:0] max_ras,
  input  logic [VW-1:0] row_total,
  input  logic [JW-1:0] adj_total,
  input  logic          frozen,
  input  logic          line_end,
  input  logic          win_last,
  input  logic          win_adj,
  output logic [RW-1:0] ras,
  output logic [VW-1:0] row,
  output logic [JW-1:0] adj,
  output logic          in_adj,
  output logic          last_flag,
  output logic          frame_wrap
);
  logic adj_arm;
  logic last_eval, arm_eval, last_now, arm_now, adj_done;

  assign last_eval = !in_adj && (ras == max_ras) && (row == row_total);
  assign last_now  = win_last ? last_eval : last_flag;
  assign arm_eval  = last_flag && !in_adj && (adj_total != '0);
  assign arm_now   = win_adj ? arm_eval : adj_arm;
  assign adj_done  = ({1'b0, adj} + (JW+1)'(1)) >= {1'b0, adj_total};
  assign frame_wrap = line_end && (in_adj ? adj_done : (last_now && !arm_now));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ras       <= '0;
      row       <= '0;
      adj       <= '0;
      in_adj    <= 1'b0;
      last_flag <= 1'b0;
      adj_arm   <= 1'b0;
    end else if (!frozen) begin
      if (win_last) last_flag <= last_eval;
      if (win_adj)  adj_arm   <= arm_eval;
      if (line_end) begin
        last_flag <= 1'b0;
        adj_arm   <= 1'b0;
        if (in_adj) begin
          if (adj_done) begin
            in_adj <= 1'b0;
            adj    <= '0;
          end else begin
            adj <= adj + JW'(1);
          end
        end else if (last_now) begin
          ras <= '0;
          row <= '0;
          adj <= '0;
          in_adj <= arm_now;
        end else if (ras == max_ras) begin
          ras <= '0;
          row <= row + VW'(1);
        end else begin
          ras <= ras + RW'(1);
        end
      end
    end
  end

  // R7: zero line length holds every vertical counter
  a_r7_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(ras) && $stable(row) && $stable(adj) && $stable(in_adj));
  // R3: vertical counters move only at a line end
  a_r3_line_only: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(ras) && $stable(row) && $stable(adj));
  // R4: the last-line verdict changes only in its window or at a line end
  a_r4_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_last && !line_end) |=> $stable(last_flag));
  // R5: the adjustment decision changes only at column 2 or a line end
  a_r5_window: assert property (@(posedge clk) disable iff (!rst_n)
    (!win_adj && !line_end) |=> $stable(adj_arm));
  // R6: adjustment begins at raster 0, row 0, count 0
  a_r6_enter: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_adj) |-> (adj == '0) && (row == '0) && (ras == '0));
endmodule

// File: rtl/raster_chain_top.sv
module raster_chain_top #(
  parameter int DW  = 8,
  parameter int HW  = 8,
  parameter int RW  = 5,
  parameter int VW  = 7,
  parameter int JW  = 5,
  parameter int SAW = 14
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           host_addr_stb,
  input  logic           host_data_stb,
  input  logic [DW-1:0]  host_data,
  output logic [HW-1:0]  col_cnt,
  output logic [RW-1:0]  raster_cnt,
  output logic [VW-1:0]  row_cnt,
  output logic [JW-1:0]  adj_cnt,
  output logic           in_adjust,
  output logic           last_line,
  output logic           frame_start,
  output logic [SAW-1:0] frame_base
);
  logic [HW-1:0]  line_len;
  logic [RW-1:0]  max_ras;
  logic [VW-1:0]  row_total;
  logic [JW-1:0]  adj_total;
  logic [SAW-1:0] start_addr;
  logic frozen, line_end, win_last, win_adj, frame_wrap, at_origin;

  raster_host_regs #(.DW(DW), .HW(HW), .RW(RW), .VW(VW), .JW(JW), .SAW(SAW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .addr_stb(host_addr_stb), .data_stb(host_data_stb), .data(host_data),
    .line_len(line_len), .max_ras(max_ras), .row_total(row_total),
    .adj_total(adj_total), .start_addr(start_addr)
  );

  raster_hcount #(.HW(HW)) u_h (
    .clk(clk), .rst_n(rst_n), .line_len(line_len), .col(col_cnt),
    .frozen(frozen), .line_end(line_end), .win_last(win_last), .win_adj(win_adj)
  );

  raster_vchain #(.RW(RW), .VW(VW), .JW(JW)) u_v (
    .clk(clk), .rst_n(rst_n), .max_ras(max_ras), .row_total(row_total),
    .adj_total(adj_total), .frozen(frozen), .line_end(line_end),
    .win_last(win_last), .win_adj(win_adj), .ras(raster_cnt), .row(row_cnt),
    .adj(adj_cnt), .in_adj(in_adjust), .last_flag(last_line), .frame_wrap(frame_wrap)
  );

  assign at_origin = (col_cnt == '0) && (raster_cnt == '0) && (row_cnt == '0) && !in_adjust;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_start <= 1'b0;
      frame_base  <= '0;
    end else begin
      frame_start <= frame_wrap;
      if (at_origin) frame_base <= start_addr;
    end
  end

  // R9: the pulse coincides with the origin
  a_r9_at_origin: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> (col_cnt == '0) && (raster_cnt == '0) && (row_cnt == '0) && !in_adjust);
  // R9: the pulse lasts a single clock
  a_r9_single: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> !frame_start);
  // R8: the base latch moves only after an origin cycle
  a_r8_base_origin: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(frame_base) |-> $past(at_origin));
endmodule

// File: tb/raster_chain_top_bench.sv
module raster_chain_top_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_addr_stb = 1'b0;
  logic host_data_stb = 1'b0;
  logic [7:0] host_data = '0;
  logic [7:0] col_cnt;
  logic [4:0] raster_cnt, adj_cnt;
  logic [6:0] row_cnt;
  logic in_adjust, last_line, frame_start;
  logic [13:0] frame_base;
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  raster_chain_top u_raster_chain_top (
    .clk(clk), .rst_n(rst_n), .host_addr_stb(host_addr_stb),
    .host_data_stb(host_data_stb), .host_data(host_data), .col_cnt(col_cnt),
    .raster_cnt(raster_cnt), .row_cnt(row_cnt), .adj_cnt(adj_cnt),
    .in_adjust(in_adjust), .last_line(last_line), .frame_start(frame_start),
    .frame_base(frame_base)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input int idx, input int val);
    @(negedge clk); host_addr_stb = 1'b1; host_data = 8'(idx);
    @(negedge clk); host_addr_stb = 1'b0; host_data_stb = 1'b1; host_data = 8'(val);
    @(negedge clk); host_data_stb = 1'b0;
  endtask

  task automatic wait_fs();
    do @(negedge clk); while (!frame_start);
  endtask

  task automatic wait_line();
    do @(negedge clk); while (col_cnt != 0);
  endtask

  task automatic wait_pos(input int r, input int s, input int c);
    do @(negedge clk); while (!(row_cnt == 7'(r) && raster_cnt == 5'(s) && col_cnt == 8'(c)));
  endtask

  task automatic measure(input string req, input int exp);
    int n = 0;
    wait_fs();
    chk("R9 origin at pulse", int'(col_cnt) + int'(raster_cnt) + int'(row_cnt) + int'(in_adjust), 0);
    do begin @(negedge clk); n++; if (n == 1) chk("R9 single pulse", int'(frame_start), 0); end
    while (!frame_start);
    chk(req, n, exp);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 col", int'(col_cnt), 0);
    chk("R1 raster/row/adj", int'(raster_cnt) + int'(row_cnt) + int'(adj_cnt), 0);
    chk("R1 flags", int'(in_adjust) + int'(last_line) + int'(frame_start), 0);
    chk("R1 base", int'(frame_base), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", int'(col_cnt) + int'(frame_start), 0);
  endtask

  task automatic t_basic();
    wr_reg(1, 1); wr_reg(2, 2); wr_reg(3, 0); wr_reg(0, 9);
    wait_fs();
    for (int i = 1; i <= 9; i++) begin
      @(negedge clk); chk("R2 column step", int'(col_cnt), i);
    end
    @(negedge clk); chk("R2 column wrap", int'(col_cnt), 0);
    chk("R3 raster advance", int'(raster_cnt), 1);
    measure("R3 frame length", 60);
  endtask

  task automatic t_decode();
    wr_reg(7, 0);
    wr_reg(6, 3);
    wr_reg(0, 9);
    @(negedge clk); host_addr_stb = 1'b1; host_data_stb = 1'b1; host_data = 8'd7;
    @(negedge clk); host_addr_stb = 1'b0; host_data_stb = 1'b0;
    @(negedge clk); host_data_stb = 1'b1; host_data = 8'd0;
    @(negedge clk); host_data_stb = 1'b0;
    measure("R10 decode leaves geometry", 60);
  endtask

  task automatic t_window();
    wait_pos(2, 1, 5);
    chk("R4 last line seen", int'(last_line), 1);
    wr_reg(2, 5);
    chk("R4 verdict held", int'(last_line), 1);
    wait_line();
    chk("R4 late write ignored: pulse", int'(frame_start), 1);
    chk("R4 late write ignored: row", int'(row_cnt), 0);
    measure("R4 new total next frame", 120);
    wait_pos(5, 0, 5);
    wr_reg(2, 6);
    wait_line();
    chk("R4 early write row", int'(row_cnt), 5);
    chk("R4 early write raster", int'(raster_cnt), 1);
    wait_line();
    chk("R4 early write continues", int'(row_cnt), 6);
    wait_fs();
    wr_reg(2, 2);
    measure("R4 restored", 60);
  endtask

  task automatic t_adjust();
    wait_fs();
    wr_reg(3, 3);
    measure("R6 frame with adjust", 90);
    do @(negedge clk); while (!in_adjust);
    chk("R6 enter col", int'(col_cnt), 0);
    chk("R6 enter counts", int'(adj_cnt) + int'(row_cnt) + int'(raster_cnt), 0);
    repeat (10) @(negedge clk);
    chk("R6 adj steps", int'(adj_cnt), 1);
    chk("R6 still adjusting", int'(in_adjust), 1);
    repeat (20) @(negedge clk);
    chk("R6 end pulse", int'(frame_start), 1);
    chk("R6 end flag", int'(in_adjust), 0);
  endtask

  task automatic t_adj_window();
    wait_pos(2, 1, 5);
    wr_reg(3, 0);
    wait_line();
    chk("R5 armed adjust kept", int'(in_adjust), 1);
    wait_line();
    chk("R5 shrink ends after one line", int'(frame_start), 1);
    chk("R5 shrink flag", int'(in_adjust), 0);
    wait_pos(2, 1, 5);
    wr_reg(3, 3);
    wait_line();
    chk("R5 late raise no adjust: pulse", int'(frame_start), 1);
    chk("R5 late raise no adjust: flag", int'(in_adjust), 0);
    measure("R5 raise applies next frame", 90);
  endtask

  task automatic t_freeze();
    wait_pos(1, 1, 3);
    wr_reg(0, 0);
    @(negedge clk);
    chk("R7 col parked", int'(col_cnt), 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (row_cnt != 1 || raster_cnt != 1 || frame_start || col_cnt != 0)
        chk("R7 hold row/raster", int'(row_cnt) * 100 + int'(raster_cnt), 101);
    end
    chk("R7 held after 20", int'(row_cnt) * 100 + int'(raster_cnt), 101);
    wr_reg(0, 9);
    do @(negedge clk); while (col_cnt != 9);
    @(negedge clk);
    chk("R7 resume next row", int'(row_cnt) * 100 + int'(raster_cnt), 200);
    do @(negedge clk); while (!(in_adjust && adj_cnt == 1 && col_cnt == 3));
    wr_reg(0, 0);
    @(negedge clk);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (adj_cnt != 1 || !in_adjust) chk("R7 adjust frozen", int'(adj_cnt), 1);
    end
    chk("R7 adjust held", int'(adj_cnt) * 10 + int'(in_adjust), 11);
    wr_reg(0, 9);
    measure("R7 after restore", 90);
  endtask

  task automatic t_base();
    wait_fs();
    wr_reg(4, 8'h2A);
    wr_reg(5, 8'h55);
    chk("R8 mid-frame unchanged", int'(frame_base), 0);
    wait_fs();
    chk("R8 not yet at origin cycle", int'(frame_base), 0);
    @(negedge clk);
    chk("R8 loaded after origin", int'(frame_base), 14'h2A55);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_decode();
    t_window();
    t_adjust();
    t_adj_window();
    t_freeze();
    t_base();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule